// File: doc/BRIEF.md
# FIFO Status Flag Generator

This block tracks how many words a single-clock synchronous FIFO of depth `DEPTH` holds, and from that count it derives four active-low status flags: an empty-side flag, a full-side flag, an almost-empty flag and an almost-full flag. The storage array sits elsewhere. The block sees only the write and read strobes and two threshold offsets: `empty_ofs` (n) and `full_ofs` (m).

Two flag conventions are supported, and the one in use is captured when synchronous reset is applied. In standard mode the empty-side pin is an empty indicator and the full-side pin is a full indicator. Both are low when the condition holds. In look-ahead mode, the first word falls through to an output register, and that register counts as one more slot. The capacity becomes `DEPTH+1` and every threshold moves by one. In this mode the empty-side pin reads as "output ready": it is low while a word is presented and high when none is. The full-side pin reads as "input ready": it is low while there is room and high when the FIFO is full.

The current word count is driven on `level` so that the flags can be related to it.

Top module: `fifo_flag_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the count becomes 0. After that edge the flags are: standard mode `empty_side_n`=0, `full_side_n`=1; look-ahead mode `empty_side_n`=1, `full_side_n`=0; in both modes `almost_empty_n`=0 and `almost_full_n`=1.
- R2: `fwft_sel` is sampled only on edges where `rst` is high (1 = look-ahead, 0 = standard). Changing it at any other time has no effect on any output.
- R3: A write that is not blocked adds one to `level`. A read that is not blocked subtracts one. When a write and a read are both accepted in the same cycle, `level` is unchanged. The count is registered and visible after the edge.
- R4: A write while `level` equals the capacity (`DEPTH` in standard mode, `DEPTH+1` in look-ahead mode) is ignored. If the same cycle carries a read that is accepted, the count still falls by one.
- R5: A read while `level` is 0 is ignored. If the same cycle carries a write that is accepted, the count still rises by one.
- R6: In standard mode, `empty_side_n` is 0 exactly when `level` is 0.
- R7: In standard mode, `full_side_n` is 0 exactly when `level` equals `DEPTH`.
- R8: In look-ahead mode, `empty_side_n` is 1 exactly when `level` is 0.
- R9: In look-ahead mode, `full_side_n` is 1 exactly when `level` equals `DEPTH+1`.
- R10: In standard mode, `almost_empty_n` is 0 exactly when `level` is at most n.
- R11: In look-ahead mode, `almost_empty_n` is 0 exactly when `level` is at most n+1.
- R12: `almost_full_n` is 0 exactly when `level` is at least the capacity minus m. The capacity is `DEPTH` in standard mode and `DEPTH+1` in look-ahead mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the mode |
| fwft_sel | input | 1 | Mode request: 1 = look-ahead, 0 = standard |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| empty_ofs | input | OFS_W | Almost-empty offset n (0 to DEPTH-1) |
| full_ofs | input | OFS_W | Almost-full offset m (0 to DEPTH-1) |
| level | output | CNT_W | Current word count |
| empty_side_n | output | 1 | Standard mode: empty (active low). Look-ahead mode: output ready (active low) |
| full_side_n | output | 1 | Standard mode: full (active low). Look-ahead mode: input ready (active low) |
| almost_empty_n | output | 1 | Almost-empty flag (active low) |
| almost_full_n | output | 1 | Almost-full flag (active low) |

## Verification
The embedded properties run on every cycle. They check that:
- the count never exceeds the capacity, and moves by at most one per cycle;
- writes at full and reads at empty leave the count alone;
- the mode holds between resets;
- the two edge flags never claim full and empty together;
- the almost flags agree with the empty and full ends.

The exact offset thresholds, and the shift by one between modes, are shown only by the bench scenarios. These scenarios sweep the count from zero to capacity and back, under several offset pairs in both modes. They also cover toggling the mode input outside reset and overlapping strobes at both ends.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fsg_mode_e;

    typedef struct packed {
        logic empty_side_n;
        logic full_side_n;
        logic almost_empty_n;
        logic almost_full_n;
    } fsg_flags_t;

    // Number of word slots, including the output register in look-ahead mode
    function automatic int unsigned fsg_capacity(input fsg_mode_e mode, input int unsigned depth);
        return (mode == MODE_FWFT) ? depth + 1 : depth;
    endfunction

    // Extra slot that shifts every threshold in look-ahead mode
    function automatic int unsigned fsg_shift(input fsg_mode_e mode);
        return (mode == MODE_FWFT) ? 1 : 0;
    endfunction

endpackage

// File: rtl/fsg_mode_latch.sv
module fsg_mode_latch
    import fsg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fwft_sel,
    output fsg_mode_e mode
);

    fsg_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= fwft_sel ? MODE_FWFT : MODE_STD;
        end
    end

    assign mode = mode_q;

    // R2: the mode only moves under reset
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode_q))
        else $error("mode changed outside reset");

endmodule

// File: rtl/fsg_word_counter.sv
module fsg_word_counter
    import fsg_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  fsg_mode_e        mode,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap
);

    localparam logic [CNT_W-1:0] CAP_STD  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CAP_FWFT = CNT_W'(DEPTH + 1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;
    logic             wr_ok;
    logic             rd_ok;

    assign cap   = (mode == MODE_FWFT) ? CAP_FWFT : CAP_STD;
    assign wr_ok = wr_en && (count_q != cap);
    assign rd_ok = rd_en && (count_q != '0);

    always_comb begin
        count_d = count_q;
        unique case ({wr_ok, rd_ok})
            2'b10:   count_d = count_q + CNT_W'(1);
            2'b01:   count_d = count_q - CNT_W'(1);
            default: count_d = count_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

    // R4: never past the capacity
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        count_q <= cap)
        else $error("count beyond capacity");

    // R4: a lone write at capacity is dropped
    p_full_write_r4: assert property (@(posedge clk) disable iff (rst)
        (count_q == cap && wr_en && !rd_en) |=> $stable(count_q))
        else $error("write at full changed count");

    // R5: a lone read at zero is dropped
    p_empty_read_r5: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0 && rd_en && !wr_en) |=> (count_q == '0))
        else $error("read at empty changed count");

    // R3: both accepted leaves the count alone
    p_rw_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && count_q != '0 && count_q != cap) |=> $stable(count_q))
        else $error("simultaneous access changed count");

    // R3: at most one step per cycle
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count_q == $past(count_q) ||
                  count_q == $past(count_q) + CNT_W'(1) ||
                  count_q == $past(count_q) - CNT_W'(1)))
        else $error("count jumped");

endmodule

// File: rtl/fsg_flag_decode.sv
module fsg_flag_decode
    import fsg_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 2),
    parameter int unsigned OFS_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  fsg_mode_e        mode,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cap,
    input  logic [OFS_W-1:0] empty_ofs,
    input  logic [OFS_W-1:0] full_ofs,
    output fsg_flags_t       flags
);

    logic [CNT_W-1:0] ae_limit;
    logic [CNT_W-1:0] af_limit;
    logic             is_zero;
    logic             is_cap;

    assign ae_limit = CNT_W'(empty_ofs) + CNT_W'(fsg_shift(mode));
    assign af_limit = cap - CNT_W'(full_ofs);
    assign is_zero  = (count == '0);
    assign is_cap   = (count == cap);

    always_comb begin
        flags = '0;
        if (mode == MODE_FWFT) begin
            flags.empty_side_n = is_zero;
            flags.full_side_n  = is_cap;
        end else begin
            flags.empty_side_n = !is_zero;
            flags.full_side_n  = !is_cap;
        end
        flags.almost_empty_n = !(count <= ae_limit);
        flags.almost_full_n  = !(count >= af_limit);
    end

    // R6 and R7: empty and full never shown together in standard mode
    p_std_excl_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STD) |-> (flags.empty_side_n || flags.full_side_n))
        else $error("standard flags both asserted");

    // R8 and R9: no data and no room never shown together in look-ahead mode
    p_fwft_excl_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FWFT) |-> !(flags.empty_side_n && flags.full_side_n))
        else $error("look-ahead flags both inactive-ready");

    // R10: an empty FIFO is always almost empty
    p_pae_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !flags.almost_empty_n)
        else $error("almost-empty off at zero");

    // R12: a full FIFO is always almost full
    p_paf_full_r12: assert property (@(posedge clk) disable iff (rst)
        (count == cap) |-> !flags.almost_full_n)
        else $error("almost-full off at capacity");

endmodule

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen
    import fsg_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 2),
    parameter int unsigned OFS_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fwft_sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFS_W-1:0] empty_ofs,
    input  logic [OFS_W-1:0] full_ofs,
    output logic [CNT_W-1:0] level,
    output logic             empty_side_n,
    output logic             full_side_n,
    output logic             almost_empty_n,
    output logic             almost_full_n
);

    fsg_mode_e        mode;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cap;
    fsg_flags_t       flags;

    fsg_mode_latch u_mode (
        .clk      (clk),
        .rst      (rst),
        .fwft_sel (fwft_sel),
        .mode     (mode)
    );

    fsg_word_counter #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .count (count),
        .cap   (cap)
    );

    fsg_flag_decode #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W),
        .OFS_W (OFS_W)
    ) u_flags (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .count     (count),
        .cap       (cap),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .flags     (flags)
    );

    assign level          = count;
    assign empty_side_n   = flags.empty_side_n;
    assign full_side_n    = flags.full_side_n;
    assign almost_empty_n = flags.almost_empty_n;
    assign almost_full_n  = flags.almost_full_n;

endmodule

// File: tb/test_fifo_flag_gen.sv
`timescale 1ns/1ps
module test_fifo_flag_gen;

    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 2);
    localparam int OFS_W = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fwft_sel = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [OFS_W-1:0] empty_ofs = '0;
    logic [OFS_W-1:0] full_ofs = '0;
    logic [CNT_W-1:0] level;
    logic             empty_side_n;
    logic             full_side_n;
    logic             almost_empty_n;
    logic             almost_full_n;

    int checks = 0;
    int errors = 0;

    // reference model state
    int    m_cnt = 0;
    bit    m_fwft = 1'b0;
    bit    m_valid = 1'b0;
    string m_tag = "R3";

    always #2.5 clk = ~clk;

    fifo_flag_gen #(.DEPTH(DEPTH)) i_fifo_flag_gen (
        .clk            (clk),
        .rst            (rst),
        .fwft_sel       (fwft_sel),
        .wr_en          (wr_en),
        .rd_en          (rd_en),
        .empty_ofs      (empty_ofs),
        .full_ofs       (full_ofs),
        .level          (level),
        .empty_side_n   (empty_side_n),
        .full_side_n    (full_side_n),
        .almost_empty_n (almost_empty_n),
        .almost_full_n  (almost_full_n)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // reference model: updated on the active edge
    always @(posedge clk) begin
        int  cap;
        bit  wok;
        bit  rok;
        if (rst) begin
            m_cnt   = 0;
            m_fwft  = fwft_sel;
            m_valid = 1'b1;
            m_tag   = "R1";
        end else begin
            cap = m_fwft ? DEPTH + 1 : DEPTH;
            wok = wr_en && (m_cnt < cap);
            rok = rd_en && (m_cnt > 0);
            if (wr_en && !wok)      m_tag = "R4";
            else if (rd_en && !rok) m_tag = "R5";
            else                    m_tag = "R3";
            m_cnt = m_cnt + int'(wok) - int'(rok);
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        int    cap;
        int    shift;
        bit    e_es, e_fs, e_ae, e_af;
        string t_es, t_fs, t_ae;
        bit    poked;
        if (m_valid) begin
            cap   = m_fwft ? DEPTH + 1 : DEPTH;
            shift = m_fwft ? 1 : 0;
            poked = (fwft_sel != m_fwft) && !rst;
            if (m_fwft) begin
                e_es = (m_cnt == 0);
                e_fs = (m_cnt == cap);
                t_es = "R8"; t_fs = "R9"; t_ae = "R11";
            end else begin
                e_es = (m_cnt != 0);
                e_fs = (m_cnt != cap);
                t_es = "R6"; t_fs = "R7"; t_ae = "R10";
            end
            e_ae = !(m_cnt <= int'(empty_ofs) + shift);
            e_af = !(m_cnt >= cap - int'(full_ofs));
            if (poked) begin
                t_es = "R2"; t_fs = "R2"; t_ae = "R2";
            end
            check(int'(level) == m_cnt, m_tag, "level", int'(level), m_cnt);
            check(empty_side_n == e_es, t_es, "empty_side_n", int'(empty_side_n), int'(e_es));
            check(full_side_n == e_fs, t_fs, "full_side_n", int'(full_side_n), int'(e_fs));
            check(almost_empty_n == e_ae, t_ae, "almost_empty_n", int'(almost_empty_n), int'(e_ae));
            check(almost_full_n == e_af, poked ? "R2" : "R12", "almost_full_n", int'(almost_full_n), int'(e_af));
        end
    end

    task automatic step(input bit w, input bit r);
        @(negedge clk);
        wr_en = w;
        rd_en = r;
    endtask

    task automatic do_reset(input bit fw, input int n, input int m);
        @(negedge clk);
        rst       = 1'b1;
        fwft_sel  = fw;
        empty_ofs = OFS_W'(n);
        full_ofs  = OFS_W'(m);
        wr_en     = 1'b0;
        rd_en     = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, explicit
        check(level == '0, "R1", "reset level", int'(level), 0);
        check(empty_side_n == fw, "R1", "reset empty_side_n", int'(empty_side_n), int'(fw));
        check(full_side_n == !fw, "R1", "reset full_side_n", int'(full_side_n), int'(!fw));
        check(almost_empty_n == 1'b0, "R1", "reset almost_empty_n", int'(almost_empty_n), 0);
        check(almost_full_n == 1'b1, "R1", "reset almost_full_n", int'(almost_full_n), 1);
    endtask

    task automatic phase(input bit fw, input int n, input int m);
        do_reset(fw, n, m);
        // R5: reads at empty, and read plus write at empty
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        // fill beyond capacity (R4)
        for (int i = 0; i < DEPTH + 4; i++) step(1'b1, 1'b0);
        // R4: write plus read at full
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        // drain beyond empty (R5)
        for (int i = 0; i < DEPTH + 4; i++) step(1'b0, 1'b1);
        // middle: overlapping strobes (R3)
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
        // random traffic with the mode input toggling outside reset (R2)
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            wr_en    = ($urandom_range(0, 99) < 55);
            rd_en    = ($urandom_range(0, 99) < 45);
            fwft_sel = (i % 37 < 18) ? !fw : fw;
        end
        step(1'b0, 1'b0);
        fwft_sel = fw;
    endtask

    initial begin
        phase(1'b0, 3, 2);
        phase(1'b0, 0, 0);
        phase(1'b0, DEPTH - 1, DEPTH - 1);
        phase(1'b1, 3, 2);
        phase(1'b1, 0, 0);
        phase(1'b1, DEPTH - 1, DEPTH - 1);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule